// File: doc/BRIEF.md
# Seconds Countdown Alarm with Wake Request

This block is a relative alarm timer. Software writes a number of seconds into an interval register, and that write also loads the live countdown. While the run bit is set, each pulse on the once-per-second tick input lowers the count by one. When the count steps from one to zero, a sticky pending flag is raised.

The pending flag feeds two outputs, each gated by its own enable bit. One is an interrupt line. The other is a wake request to the power controller. Software reads the pending flag and clears it by writing a one to its status bit.

All access goes through a plain single-cycle register port. A write is taken on the clock edge when `reg_we` is high. Read data is combinational from `reg_addr`. No write is ever refused or stalled, so the port has no back-pressure. Word addresses are: 0 interval, 1 live count, 2 run, 3 interrupt enable, 4 status, 5 wake enable. Reads of any other address return zero.

Top module: `countdown_alarm`

## Requirements
- R1: After reset, every register reads zero and both `irq` and `wake` are low.
- R2: A write to address 0 stores the value as the interval, which reads back at address 0. The same write loads the live count, which reads back at address 1 on the next cycle.
- R3: Writing 0 to address 0 clears the live count to zero, whatever its previous value.
- R4: While bit 0 of address 2 (run) is 1 and the count is nonzero, each cycle with `sec_tick` high lowers the count by exactly one. The count does not change when run is 0, when the tick is low, or when the count is already zero.
- R5: The tick that moves the count from 1 to 0 while run is set makes bit 0 of address 4 (pending) read 1 from the next cycle on. Nothing else sets the flag.
- R6: Writing a 1 in bit 0 of address 4 clears pending. Writing a 0 there leaves pending unchanged.
- R7: If pending is set and cleared in the same cycle, it ends up set.
- R8: `irq` is high exactly when pending is 1 and bit 0 of address 3 is 1.
- R9: `wake` is high exactly when pending is 1 and bit 0 of address 5 is 1.
- R10: If an interval write and a counting tick fall in the same cycle, the written value is loaded with no decrement, and pending is not set.
- R11: Address 1 is read-only. Writes to it leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse once per second |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq | output | 1 | Interrupt: pending and interrupt enable |
| wake | output | 1 | Wake request: pending and wake enable |

## Verification
The hardest case to reach is a status clear that lands in the same cycle as the count reaching zero. The stimulus has to load a count of one, set run, and then issue the clear together with the final tick. A directed sequence builds exactly that. A second directed sequence makes an interval load collide with a tick that would otherwise fire. Random stimulus then uses short intervals and frequent ticks, so that expiries often overlap with register writes of every kind.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int OFS_INTERVAL = 0;
  localparam int OFS_COUNT    = 1;
  localparam int OFS_RUN      = 2;
  localparam int OFS_IRQ_EN   = 3;
  localparam int OFS_STATUS   = 4;
  localparam int OFS_WAKE_EN  = 5;
endpackage

// File: rtl/alarm_regs.sv
module alarm_regs
  import alarm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] cnt,
  input  logic              pend,
  output logic [DATA_W-1:0] rdata,
  output logic              run,
  output logic              ie,
  output logic              wk,
  output logic              load,
  output logic              clr
);
  logic [DATA_W-1:0] interval_q;

  // address decode for the write strobes
  assign load = we && (addr == ADDR_W'(OFS_INTERVAL));
  assign clr  = we && (addr == ADDR_W'(OFS_STATUS)) && wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      interval_q <= '0;
      run        <= 1'b0;
      ie         <= 1'b0;
      wk         <= 1'b0;
    end else if (we) begin
      case (addr)
        ADDR_W'(OFS_INTERVAL): interval_q <= wdata;
        ADDR_W'(OFS_RUN):      run        <= wdata[0];
        ADDR_W'(OFS_IRQ_EN):   ie         <= wdata[0];
        ADDR_W'(OFS_WAKE_EN):  wk         <= wdata[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_W'(OFS_INTERVAL): rdata = interval_q;
      ADDR_W'(OFS_COUNT):    rdata = cnt;
      ADDR_W'(OFS_RUN):      rdata[0] = run;
      ADDR_W'(OFS_IRQ_EN):   rdata[0] = ie;
      ADDR_W'(OFS_STATUS):   rdata[0] = pend;
      ADDR_W'(OFS_WAKE_EN):  rdata[0] = wk;
      default:               rdata = '0;
    endcase
  end
endmodule

// File: rtl/alarm_counter.sv
module alarm_counter #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic              run,
  input  logic              tick,
  output logic [DATA_W-1:0] cnt,
  output logic              fire
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic step;
  assign step = run && tick && (cnt != '0) && !load;
  // a load takes the place of the last decrement, so it also suppresses the expiry
  assign fire = step && (cnt == ONE);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= load_val;
    else if (step) cnt <= cnt - ONE;
  end
endmodule

// File: rtl/alarm_pending.sv
module alarm_pending (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic pend
);
  always_ff @(posedge clk) begin
    if (!rst_n)   pend <= 1'b0;
    else if (set) pend <= 1'b1;  // a set beats a clear in the same cycle
    else if (clr) pend <= 1'b0;
  end
endmodule

// File: rtl/countdown_alarm.sv
module countdown_alarm #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq,
  output logic              wake
);
  logic [DATA_W-1:0] cnt_q;
  logic pend_q, run_q, ie_q, wk_q, load_s, clr_s, fire_s;

  alarm_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .cnt(cnt_q), .pend(pend_q), .rdata(reg_rdata),
    .run(run_q), .ie(ie_q), .wk(wk_q), .load(load_s), .clr(clr_s)
  );

  alarm_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(load_s), .load_val(reg_wdata),
    .run(run_q), .tick(sec_tick), .cnt(cnt_q), .fire(fire_s)
  );

  alarm_pending u_pend (
    .clk(clk), .rst_n(rst_n), .set(fire_s), .clr(clr_s), .pend(pend_q)
  );

  assign irq  = pend_q && ie_q;
  assign wake = pend_q && wk_q;
endmodule

// File: rtl/alarm_chk.sv
module alarm_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sec_tick,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              irq,
  input logic              wake,
  input logic [DATA_W-1:0] cnt,
  input logic              pend,
  input logic              run,
  input logic              ie,
  input logic              wk
);
  logic ld, cnt_wr, expire, clear1;
  assign ld     = reg_we && (reg_addr == ADDR_W'(0));
  assign cnt_wr = reg_we && (reg_addr == ADDR_W'(1));
  assign expire = run && sec_tick && (cnt == DATA_W'(1)) && !ld;
  assign clear1 = reg_we && (reg_addr == ADDR_W'(4)) && reg_wdata[0];

  // R2
  load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> cnt == $past(reg_wdata));
  // R4
  step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && sec_tick && cnt != '0 && !ld) |=> cnt == $past(cnt) - DATA_W'(1));
  // R4
  hold_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && !(run && sec_tick && cnt != '0)) |=> $stable(cnt));
  // R5
  expire_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> pend);
  // R5
  rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $past(expire));
  // R6
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clear1 && !expire) |=> !pend);
  // R8
  irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (pend && ie));
  // R9
  wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> (pend && wk));
  // R11
  ro_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_wr && !(run && sec_tick && cnt != '0)) |=> $stable(cnt));
endmodule

bind countdown_alarm alarm_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .reg_we(reg_we),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .irq(irq), .wake(wake),
  .cnt(cnt_q), .pend(pend_q), .run(run_q), .ie(ie_q), .wk(wk_q)
);

// File: tb/sim_countdown_alarm.sv
module sim_countdown_alarm;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int AW = 3;

  logic clk = 1'b0, rst_n = 1'b0, sec_tick = 1'b0, reg_we = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic irq, wake;
  int total = 0, bad = 0, cycles = 0;
  bit finished = 0;

  // model state
  logic [DW-1:0] m_int = '0, m_cnt = '0;
  logic m_run = 0, m_ie = 0, m_wk = 0, m_pend = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  countdown_alarm #(.DATA_W(DW), .ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .wake(wake)
  );

  function automatic logic [DW-1:0] exp_rd(input logic [AW-1:0] a);
    case (a)
      3'd0: return m_int;
      3'd1: return m_cnt;
      3'd2: return DW'(m_run);
      3'd3: return DW'(m_ie);
      3'd4: return DW'(m_pend);
      3'd5: return DW'(m_wk);
      default: return '0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one cycle: drive, compare current state, then advance the model
  task automatic cyc(input logic tk, input logic we, input logic [AW-1:0] a,
                     input logic [DW-1:0] d, input string tag);
    logic ld, fire;
    @(negedge clk);
    sec_tick = tk; reg_we = we; reg_addr = a; reg_wdata = d;
    #1;
    if (!we) check({tag, " rdata"}, reg_rdata, exp_rd(a));
    check("R8 irq", DW'(irq), DW'(m_pend && m_ie));
    check("R9 wake", DW'(wake), DW'(m_pend && m_wk));
    ld = we && a == 3'd0;
    fire = m_run && tk && m_cnt == DW'(1) && !ld;
    if (ld) m_cnt = d;
    else if (m_run && tk && m_cnt != '0) m_cnt = m_cnt - 1;
    if (fire) m_pend = 1;
    else if (we && a == 3'd4 && d[0]) m_pend = 0;
    if (we) case (a)
      3'd0: m_int = d;
      3'd2: m_run = d[0];
      3'd3: m_ie = d[0];
      3'd5: m_wk = d[0];
      default: ;
    endcase
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    cyc(1'b0, 1'b1, a, d, "wr");
  endtask

  task automatic rd(input logic [AW-1:0] a, input string tag);
    cyc(1'b0, 1'b0, a, '0, tag);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        total++; bad++;
        $display("FAIL watchdog: actual=expired expected=done");
        summary();
      end
    end
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 8; a++) rd(AW'(a), "R1");
    // R2 load and read back
    wr(3'd0, 32'hDEAD_0007);
    rd(3'd0, "R2"); rd(3'd1, "R2");
    // R11 count register ignores writes
    wr(3'd1, 32'h55); rd(3'd1, "R11");
    // R3 writing zero clears
    wr(3'd0, 32'd0); rd(3'd1, "R3");
    // R4 ticks without run do nothing
    wr(3'd0, 32'd3);
    cyc(1, 0, 3'd1, 0, "R4"); rd(3'd1, "R4");
    // R4 R5 run down to zero, R8 R9 with enables
    wr(3'd3, 1); wr(3'd5, 1); wr(3'd2, 1);
    cyc(1, 0, 3'd1, 0, "R4"); cyc(0, 0, 3'd1, 0, "R4");
    cyc(1, 0, 3'd1, 0, "R4"); cyc(1, 0, 3'd4, 0, "R5");
    rd(3'd4, "R5"); rd(3'd1, "R4");
    cyc(1, 0, 3'd1, 0, "R4");  // holds at zero
    // R6 write of 0 ignored, write of 1 clears
    wr(3'd4, 0); rd(3'd4, "R6");
    wr(3'd4, 1); rd(3'd4, "R6");
    // R7 set beats clear
    wr(3'd0, 1);
    cyc(1, 1, 3'd4, 1, "R7"); rd(3'd4, "R7");
    wr(3'd4, 1);
    // R10 load collides with expiring tick
    wr(3'd0, 1);
    cyc(1, 1, 3'd0, 32'd9, "R10"); rd(3'd1, "R10"); rd(3'd4, "R10");
    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic tk, we;
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      tk = ($urandom % 3) != 0;
      we = ($urandom % 4) == 0;
      a = AW'($urandom % 7);
      d = ($urandom % 2) ? DW'($urandom % 5) : $urandom;
      if (we && a == 3'd0 && ($urandom % 2)) d = DW'($urandom % 4);
      cyc(tk, we, a, d, "R4 R5 random");
    end
    rd(3'd1, "R4");
    summary();
  end
endmodule